// File: doc/BRIEF.md
# Thermal Sensor Code Calibration Converter

This block translates between the 8-bit code produced by an on-die thermal sensor and a temperature in whole degrees Celsius, in either direction. The translation depends on per-die trim: a 32-bit fused word carries two 8-bit error codes, E1 and E2. These are the codes the sensor reported at two reference temperatures, T1 and T2. Before use, each error code is screened. A value that is missing or outside the allowed window is replaced by the matching byte of a default word.

Three calibration modes are available. In the fixed-offset mode the code is the temperature plus a constant. In the single-point mode the code is shifted by the E1 error relative to T1. In the dual-point mode the code is a linear interpolation through (T1, E1) and (T2, E2). The dual-point mode needs a true division, which runs on a small sequential divider that retires two quotient bits per cycle. While the divider runs, the block holds off new requests. A request is a value plus a direction bit, presented with a valid/ready handshake. The answer comes back as a signed result with a one-cycle valid pulse and an error flag.

Top module: `therm_code_xlat`

## Requirements
- R1: With `cal_mode` 0 or 3 (fixed offset), a temperature-to-code request (`req_to_temp`=0) returns value + `base_offset`, and a code-to-temperature request (`req_to_temp`=1) returns value − `base_offset`, as a signed result that may be negative.
- R2: With `cal_mode` 1 (single point), temperature-to-code returns value + E1 − T1, and code-to-temperature returns value − E1 + T1.
- R3: With `cal_mode` 2 (dual point), temperature-to-code returns (value − T1)·(E2 − E1)/(T2 − T1) + E1. The quotient truncates toward zero, so a negative quotient is rounded up, not floored.
- R4: With `cal_mode` 2, code-to-temperature returns (value − E1)·(T2 − T1)/(E2 − E1) + T1, with the quotient truncated toward zero.
- R5: E1 is `trim_word` bits [7:0]. It is replaced by bits [7:0] of `default_trim` when it is zero, below `e1_floor` or above `e1_ceil`. Values equal to either limit are kept.
- R6: E2 is the byte of `trim_word` starting at bit TRIM_SHIFT (default 8). It is replaced by the same byte of `default_trim` only when it is zero. The E1 limits do not apply to it.
- R7: In `cal_mode` 2, when the screened E2 equals E1 or T2 equals T1, the request is answered with `rsp_error`=1 and result 0 in the cycle after acceptance. Other modes never raise `rsp_error`, even when E1 equals E2.
- R8: A request accepted in modes 0, 1 or 3, or an error answer, produces `rsp_valid` in the cycle right after the accepting edge. `rsp_valid` is a single-cycle pulse.
- R9: A dual-point request that divides raises `busy` and drops `req_ready` from the cycle after acceptance. The answer arrives ten cycles later than the one-cycle path. `busy` falls as `rsp_valid` rises. Requests offered while `busy` is high are neither accepted nor answered.
- R10: After reset, `rsp_valid`, `rsp_error` and `busy` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_mode | input | 2 | 0/3 fixed offset, 1 single point, 2 dual point |
| trim_word | input | 32 | Fused trim word holding E1 and E2 |
| default_trim | input | 32 | Fallback word, same layout as trim_word |
| e1_floor | input | CODE_W | Lowest acceptable E1 |
| e1_ceil | input | CODE_W | Highest acceptable E1 |
| ref_lo_temp | input | CODE_W | First reference temperature T1 |
| ref_hi_temp | input | CODE_W | Second reference temperature T2 |
| base_offset | input | CODE_W | Offset used by the fixed-offset mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_to_temp | input | 1 | 1: code to temperature, 0: temperature to code |
| req_value | input | CODE_W | Unsigned operand |
| busy | output | 1 | Dual-point division in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_error | output | 1 | Result invalid: zero divisor in dual-point mode |
| rsp_result | output | WIDE_W | Signed result |

## Verification
Every direct answer is registered on the accepting edge, so it is due at the first falling edge after that edge. A dividing answer takes nine divider steps plus one output register, so it is due at the eleventh falling edge. Each scenario task raises the request at a falling edge and drops it after the accepting edge. It then counts falling edges until the valid strobe appears and checks the count against 1 or 11 before comparing the result. It also checks at the following falling edge that the strobe has ended. The test that offers requests while busy keeps watching for fifteen more cycles after the real answer, so that an answer to a wrongly accepted request would be seen.

// File: rtl/therm_xlat_pkg.sv
// Shared types for the thermal code converter.
package therm_xlat_pkg;
    typedef enum logic [1:0] {
        CAL_FIXED     = 2'd0,
        CAL_SINGLE    = 2'd1,
        CAL_DUAL      = 2'd2,
        CAL_FIXED_ALT = 2'd3
    } cal_mode_e;
endpackage

// File: rtl/trim_sanitizer.sv
// Extracts the two error codes from the fused trim word and swaps in the
// default bytes where the fused ones are unusable.
// Assumes TRIM_SHIFT + CODE_W <= FUSE_W. Purely combinational.
module trim_sanitizer #(
    parameter int CODE_W     = 8,
    parameter int FUSE_W     = 32,
    parameter int TRIM_SHIFT = 8
) (
    input  logic [FUSE_W-1:0] trim_word,
    input  logic [FUSE_W-1:0] default_trim,
    input  logic [CODE_W-1:0] e1_floor,
    input  logic [CODE_W-1:0] e1_ceil,
    output logic [CODE_W-1:0] e1_code,
    output logic [CODE_W-1:0] e2_code
);
    logic [CODE_W-1:0] e1_raw, e2_raw;
    logic              e1_reject;

    // Field extraction and screening of both error codes
    always_comb begin
        e1_raw    = trim_word[CODE_W-1:0];
        e2_raw    = trim_word[TRIM_SHIFT +: CODE_W];
        e1_reject = (e1_raw == '0) || (e1_raw < e1_floor) || (e1_raw > e1_ceil);
        e1_code   = e1_reject ? default_trim[CODE_W-1:0] : e1_raw;
        e2_code   = (e2_raw == '0) ? default_trim[TRIM_SHIFT +: CODE_W] : e2_raw;
    end
endmodule

// File: rtl/cal_datapath.sv
// Arithmetic front end: computes the direct answer for the offset and
// single-point modes, and the dividend, divisor and final addend for the
// dual-point mode. Operands are unsigned CODE_W; all arithmetic is signed
// WIDE_W, which must exceed 2*CODE_W+1 bits for the product to fit.
module cal_datapath
    import therm_xlat_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int WIDE_W = 18
) (
    input  cal_mode_e                 mode,
    input  logic                      to_temp,
    input  logic [CODE_W-1:0]         operand,
    input  logic [CODE_W-1:0]         e1_code,
    input  logic [CODE_W-1:0]         e2_code,
    input  logic [CODE_W-1:0]         t1_temp,
    input  logic [CODE_W-1:0]         t2_temp,
    input  logic [CODE_W-1:0]         offset,
    output logic signed [WIDE_W-1:0]  direct_res,
    output logic signed [WIDE_W-1:0]  div_num,
    output logic signed [WIDE_W-1:0]  div_den,
    output logic signed [WIDE_W-1:0]  div_base,
    output logic                      needs_div,
    output logic                      cal_bad
);
    localparam int PAD_W = WIDE_W - CODE_W;

    function automatic logic signed [WIDE_W-1:0] widen(input logic [CODE_W-1:0] v);
        return $signed({{PAD_W{1'b0}}, v});
    endfunction

    logic signed [WIDE_W-1:0] op_w, e1_w, e2_w, t1_w, t2_w, off_w;
    logic signed [WIDE_W-1:0] lin_diff, lin_scale;

    // Widening of all operands to the signed working width
    always_comb begin
        op_w  = widen(operand);
        e1_w  = widen(e1_code);
        e2_w  = widen(e2_code);
        t1_w  = widen(t1_temp);
        t2_w  = widen(t2_temp);
        off_w = widen(offset);
    end

    // Direct answer for the modes that need no division
    always_comb begin
        case (mode)
            CAL_SINGLE: direct_res = to_temp ? (op_w - e1_w + t1_w) : (op_w + e1_w - t1_w);
            default:    direct_res = to_temp ? (op_w - off_w) : (op_w + off_w);
        endcase
    end

    // Dividend, divisor and addend for the dual-point interpolation
    always_comb begin
        lin_diff  = to_temp ? (op_w - e1_w) : (op_w - t1_w);
        lin_scale = to_temp ? (t2_w - t1_w) : (e2_w - e1_w);
        div_den   = to_temp ? (e2_w - e1_w) : (t2_w - t1_w);
        div_base  = to_temp ? t1_w : e1_w;
        div_num   = lin_diff * lin_scale;
        needs_div = (mode == CAL_DUAL);
        cal_bad   = (e1_code == e2_code) || (t1_temp == t2_temp);
    end
endmodule

// File: rtl/seq_divider.sv
// Signed restoring divider, BPC quotient bits per cycle, truncating toward
// zero. A start pulse loads the operands; done pulses one cycle after the
// final step. Assumes a non-zero divisor and no start while running.
module seq_divider #(
    parameter int NUM_W = 18,
    parameter int BPC   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [NUM_W-1:0]  dividend,
    input  logic signed [NUM_W-1:0]  divisor,
    output logic                     done,
    output logic signed [NUM_W-1:0]  quotient
);
    localparam int STEPS = (NUM_W + BPC - 1) / BPC;
    localparam int PAD_W = STEPS * BPC;
    localparam int CNT_W = $clog2(STEPS + 1);

    logic [PAD_W-1:0] acc_q, acc_n;
    logic [NUM_W:0]   rem_q, rem_n;
    logic [NUM_W-1:0] den_mag_q;
    logic [NUM_W-1:0] num_mag, den_mag;
    logic [CNT_W-1:0] cnt_q;
    logic             neg_q;
    logic             done_q;

    // Operand magnitudes for loading
    always_comb begin
        num_mag = dividend[NUM_W-1] ? NUM_W'(-dividend) : NUM_W'(dividend);
        den_mag = divisor[NUM_W-1]  ? NUM_W'(-divisor)  : NUM_W'(divisor);
    end

    // BPC restoring steps chained in one cycle
    always_comb begin
        rem_n = rem_q;
        acc_n = acc_q;
        for (int i = 0; i < BPC; i++) begin
            rem_n = {rem_n[NUM_W-1:0], acc_n[PAD_W-1]};
            acc_n = {acc_n[PAD_W-2:0], 1'b0};
            if (rem_n >= {1'b0, den_mag_q}) begin
                rem_n    = rem_n - {1'b0, den_mag_q};
                acc_n[0] = 1'b1;
            end
        end
    end

    // Load on start, then iterate until the step counter runs out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            rem_q     <= '0;
            den_mag_q <= '0;
            cnt_q     <= '0;
            neg_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                acc_q     <= PAD_W'(num_mag);
                rem_q     <= '0;
                den_mag_q <= den_mag;
                neg_q     <= dividend[NUM_W-1] ^ divisor[NUM_W-1];
                cnt_q     <= CNT_W'(STEPS);
            end else if (cnt_q != '0) begin
                acc_q <= acc_n;
                rem_q <= rem_n;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
            end
        end
    end

    // Sign restoration of the truncated magnitude
    always_comb begin
        quotient = neg_q ? -$signed(acc_q[NUM_W-1:0]) : $signed(acc_q[NUM_W-1:0]);
        done     = done_q;
    end
endmodule

// File: rtl/therm_code_xlat.sv
// Top level of the thermal code converter. Accepts one request per cycle
// on the direct path; a dual-point request occupies the divider and blocks
// the handshake until its answer is out. Configuration inputs are assumed
// stable while a request is in flight.
module therm_code_xlat
    import therm_xlat_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int WIDE_W     = 18,
    parameter int FUSE_W     = 32,
    parameter int TRIM_SHIFT = 8,
    parameter int DIV_BPC    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cal_mode,
    input  logic [FUSE_W-1:0]        trim_word,
    input  logic [FUSE_W-1:0]        default_trim,
    input  logic [CODE_W-1:0]        e1_floor,
    input  logic [CODE_W-1:0]        e1_ceil,
    input  logic [CODE_W-1:0]        ref_lo_temp,
    input  logic [CODE_W-1:0]        ref_hi_temp,
    input  logic [CODE_W-1:0]        base_offset,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_to_temp,
    input  logic [CODE_W-1:0]        req_value,
    output logic                     busy,
    output logic                     rsp_valid,
    output logic                     rsp_error,
    output logic signed [WIDE_W-1:0] rsp_result
);
    cal_mode_e                mode_e;
    logic [CODE_W-1:0]        e1_code, e2_code;
    logic signed [WIDE_W-1:0] direct_res, div_num, div_den, div_base, quot;
    logic signed [WIDE_W-1:0] base_q;
    logic                     needs_div, cal_bad, div_done;
    logic                     busy_q, accept, div_start;

    assign mode_e = cal_mode_e'(cal_mode);

    trim_sanitizer #(
        .CODE_W(CODE_W), .FUSE_W(FUSE_W), .TRIM_SHIFT(TRIM_SHIFT)
    ) u_trim (
        .trim_word(trim_word), .default_trim(default_trim),
        .e1_floor(e1_floor), .e1_ceil(e1_ceil),
        .e1_code(e1_code), .e2_code(e2_code)
    );

    cal_datapath #(.CODE_W(CODE_W), .WIDE_W(WIDE_W)) u_path (
        .mode(mode_e), .to_temp(req_to_temp), .operand(req_value),
        .e1_code(e1_code), .e2_code(e2_code),
        .t1_temp(ref_lo_temp), .t2_temp(ref_hi_temp), .offset(base_offset),
        .direct_res(direct_res), .div_num(div_num), .div_den(div_den),
        .div_base(div_base), .needs_div(needs_div), .cal_bad(cal_bad)
    );

    seq_divider #(.NUM_W(WIDE_W), .BPC(DIV_BPC)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(div_num), .divisor(div_den),
        .done(div_done), .quotient(quot)
    );

    // Handshake decode
    always_comb begin
        req_ready = !busy_q;
        accept    = req_valid && req_ready;
        div_start = accept && needs_div && !cal_bad;
        busy      = busy_q;
    end

    // Response register and divide-in-progress tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            base_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_error  <= 1'b0;
            rsp_result <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            if (accept && !needs_div) begin
                rsp_valid  <= 1'b1;
                rsp_result <= direct_res;
            end else if (accept && cal_bad) begin
                rsp_valid  <= 1'b1;
                rsp_error  <= 1'b1;
                rsp_result <= '0;
            end else if (div_start) begin
                busy_q <= 1'b1;
                base_q <= div_base;
            end
            if (div_done) begin
                busy_q     <= 1'b0;
                rsp_valid  <= 1'b1;
                rsp_result <= quot + base_q;
            end
        end
    end
endmodule

// File: rtl/therm_xlat_chk.sv
// Protocol and timing checks on the converter's ports.
module therm_xlat_chk #(
    parameter int CODE_W  = 8,
    parameter int WIDE_W  = 18,
    parameter int DIV_BPC = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               cal_mode,
    input logic [CODE_W-1:0]        base_offset,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     req_to_temp,
    input logic [CODE_W-1:0]        req_value,
    input logic                     busy,
    input logic                     rsp_valid,
    input logic                     rsp_error,
    input logic signed [WIDE_W-1:0] rsp_result
);
    localparam int MAX_BUSY = (WIDE_W + DIV_BPC - 1) / DIV_BPC + 1;

    logic                     acc;
    logic signed [WIDE_W-1:0] fwd_sum;
    logic [7:0]               busy_run;

    assign acc     = req_valid && req_ready;
    assign fwd_sum = $signed({{(WIDE_W-CODE_W){1'b0}}, req_value})
                   + $signed({{(WIDE_W-CODE_W){1'b0}}, base_offset});

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    assert_offset_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cal_mode == 2'd0 && !req_to_temp) |=> (rsp_result == $past(fwd_sum)));

    assert_error_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_valid && rsp_result == '0));

    assert_direct_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cal_mode != 2'd2) |=> (rsp_valid && !rsp_error && !busy));

    assert_dual_occupies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cal_mode == 2'd2) |=> (busy || rsp_error));

    assert_busy_ends_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 8'(MAX_BUSY));
endmodule

bind therm_code_xlat therm_xlat_chk #(
    .CODE_W(CODE_W), .WIDE_W(WIDE_W), .DIV_BPC(DIV_BPC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .base_offset(base_offset),
    .req_valid(req_valid), .req_ready(req_ready), .req_to_temp(req_to_temp),
    .req_value(req_value), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_error(rsp_error), .rsp_result(rsp_result)
);

// File: tb/sim_therm_code_xlat.sv
module sim_therm_code_xlat;
    localparam int CODE_W = 8;
    localparam int WIDE_W = 18;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [1:0]               cal_mode = '0;
    logic [31:0]              trim_word = '0, default_trim = '0;
    logic [CODE_W-1:0]        e1_floor = '0, e1_ceil = '0;
    logic [CODE_W-1:0]        ref_lo_temp = '0, ref_hi_temp = '0, base_offset = '0;
    logic                     req_valid = 1'b0, req_to_temp = 1'b0;
    logic [CODE_W-1:0]        req_value = '0;
    logic                     req_ready, busy, rsp_valid, rsp_error;
    logic signed [WIDE_W-1:0] rsp_result;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    therm_code_xlat u0 (
        .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .trim_word(trim_word),
        .default_trim(default_trim), .e1_floor(e1_floor), .e1_ceil(e1_ceil),
        .ref_lo_temp(ref_lo_temp), .ref_hi_temp(ref_hi_temp),
        .base_offset(base_offset), .req_valid(req_valid), .req_ready(req_ready),
        .req_to_temp(req_to_temp), .req_value(req_value), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_result(rsp_result)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Default config: E1=50 E2=110 fused, defaults E1=55 E2=80, window 40..100
    task automatic setup(int mode, int trim, int t1 = 25, int t2 = 85, int off = 50);
        @(negedge clk);
        cal_mode     = 2'(mode);
        trim_word    = 32'(trim);
        default_trim = 32'h0000_5037;
        e1_floor     = 8'd40;
        e1_ceil      = 8'd100;
        ref_lo_temp  = 8'(t1);
        ref_hi_temp  = 8'(t2);
        base_offset  = 8'(off);
    endtask

    task automatic xlat(string tag, bit to_temp, int val, int exp_res, int exp_err, int exp_lat);
        int lat;
        @(negedge clk);
        chk({tag, " ready"}, int'(req_ready), 1);
        req_valid   = 1'b1;
        req_to_temp = to_temp;
        req_value   = 8'(val);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk({tag, " latency"}, lat, exp_lat);
        chk({tag, " result"}, int'(rsp_result), exp_res);
        chk({tag, " error"}, int'(rsp_error), exp_err);
        @(negedge clk);
        chk({tag, " pulse"}, int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 rsp_valid", int'(rsp_valid), 0);
        chk("R10 rsp_error", int'(rsp_error), 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 req_ready", int'(req_ready), 1);
    endtask

    task automatic t_offset();
        setup(0, 32'h6E32);
        xlat("R1 fwd", 0, 30, 80, 0, 1);
        xlat("R1 inv", 1, 80, 30, 0, 1);
        xlat("R1 inv negative", 1, 10, -40, 0, 1);
        setup(3, 32'h6E32);
        xlat("R1 mode3 fwd", 0, 200, 250, 0, 1);
        xlat("R8 mode3 inv", 1, 255, 205, 0, 1);
    endtask

    task automatic t_single();
        setup(1, 32'h6E32);
        xlat("R2 fwd", 0, 40, 65, 0, 1);
        xlat("R2 inv", 1, 65, 40, 0, 1);
    endtask

    task automatic t_e1_screen();
        setup(1, 32'h6E00);
        xlat("R5 zero E1", 0, 40, 70, 0, 1);
        setup(1, 32'h6E1E);
        xlat("R5 E1 below floor", 0, 40, 70, 0, 1);
        setup(1, 32'h6E78);
        xlat("R5 E1 above ceil", 0, 40, 70, 0, 1);
        setup(1, 32'h6E28);
        xlat("R5 E1 at floor", 0, 40, 55, 0, 1);
        setup(1, 32'h6E64);
        xlat("R5 E1 at ceil", 0, 40, 115, 0, 1);
    endtask

    task automatic t_dual();
        setup(2, 32'h6432);
        xlat("R3 fwd trunc", 0, 30, 54, 0, 11);
        xlat("R3 fwd negative toward zero", 0, 20, 46, 0, 11);
        xlat("R3 fwd max", 0, 255, 241, 0, 11);
        xlat("R3 fwd at T1", 0, 25, 50, 0, 11);
        xlat("R4 inv", 1, 54, 29, 0, 11);
        xlat("R4 inv exact negative", 1, 45, 19, 0, 11);
        xlat("R4 inv negative toward zero", 1, 47, 22, 0, 11);
    endtask

    task automatic t_e2_screen();
        setup(2, 32'h0032);
        xlat("R6 zero E2 default", 0, 55, 65, 0, 11);
        setup(2, 32'h0132);
        xlat("R6 small E2 kept", 0, 55, 26, 0, 11);
    endtask

    task automatic t_error();
        setup(2, 32'h3C3C);
        xlat("R7 E2 equals E1", 0, 40, 0, 1, 1);
        setup(2, 32'h6432, 25, 25);
        xlat("R7 T2 equals T1", 1, 60, 0, 1, 1);
        setup(1, 32'h3C3C);
        xlat("R7 single mode no error", 0, 40, 75, 0, 1);
    endtask

    task automatic t_busy();
        int lat;
        int extra;
        setup(2, 32'h6432);
        @(negedge clk);
        req_valid   = 1'b1;
        req_to_temp = 1'b0;
        req_value   = 8'd30;
        @(posedge clk);
        @(negedge clk);
        req_value = 8'd255;
        chk("R9 busy raised", int'(busy), 1);
        chk("R9 ready dropped", int'(req_ready), 0);
        lat = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 latency", lat, 11);
        chk("R9 result of first request", int'(rsp_result), 54);
        chk("R9 busy cleared with answer", int'(busy), 0);
        extra = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (rsp_valid) extra++;
        end
        chk("R9 offered request ignored", extra, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offset();
        t_single();
        t_e1_screen();
        t_dual();
        t_e2_screen();
        t_error();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule